// File: doc/BRIEF.md
# Bus-Addressed 16-bit Arithmetic Unit

This block puts a 16-bit arithmetic/logic unit behind a two-wire serial bus. Four register nodes sit on the bus as separate targets: two operands, one operation selector and one result. A bus controller writes the operands and the selector, and then reads the result. The controller never sees how the result is computed, so the unit behaves as a compute peripheral that only exposes registers.

Each node takes its 7-bit bus address from an input port. Changing a port moves that register to a new address without any change to the logic. SCL and SDA are oversampled on the system clock. The block drives the lines only through open-drain enables. It can pull SDA low, and it never pulls SCL low. Every transfer is a START, then an address byte with the direction bit, then data bytes with acknowledge bits, then a STOP.

Top module: `i2c_alu_regs`

## Requirements
- R1: After reset, `sda_oe` and `scl_oe` are 0. Every register, including the result, reads back as 0x0000.
- R2: The address byte is the 7-bit address followed by a direction bit (0 write, 1 read). The node whose address port matches pulls SDA low during the ninth clock of that byte.
- R3: When no node matches the address, SDA stays released for that byte and for every later byte until the next START. No register changes.
- R4: A write carries the 16-bit value as two bytes, high byte first. Every data byte is acknowledged. The register takes the new value only after the second byte.
- R5: A read returns the node's current 16-bit value, high byte first, from any of the four nodes. A NACK from the controller ends the read, and the node then releases SDA.
- R6: The low 3 bits of the selector register choose the operation: 0 A+B, 1 A-B, 2 A AND B, 3 A OR B, 4 A XOR B, 5 A shifted left by one, 6 A shifted right by one (zero fill), 7 A. All results wrap to 16 bits.
- R7: The result register is recomputed after every write to an operand or to the selector.
- R8: A write addressed to the result node is acknowledged, but it leaves the result unchanged.
- R9: A START or a STOP that arrives before a write is complete throws away the partial data. The target register keeps its old value.
- R10: `scl_oe` is always 0. SDA is released after every STOP. The SDA drive changes only while SCL is low, except at START or STOP.
- R11: Changing an address port while the bus is idle moves the node. The old address no longer gets an acknowledge and the new address does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| addr_opa | input | 7 | Bus address of operand A |
| addr_opb | input | 7 | Bus address of operand B |
| addr_ctl | input | 7 | Bus address of the operation selector |
| addr_res | input | 7 | Bus address of the result |
| scl_oe | output | 1 | SCL pull-down enable (held at 0) |
| sda_oe | output | 1 | SDA pull-down enable |

## Verification
The checks assume that the four address ports hold distinct values, so at most one write strobe can fire in any cycle. They also assume that the controller changes SDA only while SCL is low, except when it signals START or STOP. Each SCL phase must last longer than the two-flop synchronizer plus one register, so that the node's drive settles before the next rising edge. The bench holds every SCL quarter-period for eight system clocks. It uses four distinct addresses and changes an address only between transfers, so the stimulus stays inside these assumptions.

// File: rtl/i2c_alu_pkg.sv
package i2c_alu_pkg;

  localparam int BUS_ADDR_W = 7;
  localparam int OP_SEL_W   = 3;

  typedef enum logic [OP_SEL_W-1:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_SHL  = 3'd5,
    OP_SHR  = 3'd6,
    OP_PASS = 3'd7
  } alu_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK
  } node_st_e;

endpackage

// File: rtl/i2c_alu_core.sv
module i2c_alu_core
  import i2c_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  alu_op_e           op,
  output logic [DATA_W-1:0] y
);

  always_comb begin
    unique case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_SHL:  y = {a[DATA_W-2:0], 1'b0};
      OP_SHR:  y = {1'b0, a[DATA_W-1:1]};
      default: y = a;
    endcase
  end

endmodule

// File: rtl/i2c_bus_sense.sv
module i2c_bus_sense (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);

  logic scl_m, sda_m, scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_m   <= 1'b1;
      sda_m   <= 1'b1;
      scl_lvl <= 1'b1;
      sda_lvl <= 1'b1;
      scl_p   <= 1'b1;
      sda_p   <= 1'b1;
    end else begin
      scl_m   <= scl_i;
      sda_m   <= sda_i;
      scl_lvl <= scl_m;
      sda_lvl <= sda_m;
      scl_p   <= scl_lvl;
      sda_p   <= sda_lvl;
    end
  end

  assign scl_rise = scl_lvl & ~scl_p;
  assign scl_fall = ~scl_lvl & scl_p;
  assign start_p  = scl_lvl & scl_p & sda_p & ~sda_lvl;
  assign stop_p   = scl_lvl & scl_p & ~sda_p & sda_lvl;

endmodule

// File: rtl/i2c_reg_node.sv
module i2c_reg_node
  import i2c_alu_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter bit WRITABLE = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [BUS_ADDR_W-1:0] my_addr,
  input  logic                  scl_rise,
  input  logic                  scl_fall,
  input  logic                  start_p,
  input  logic                  stop_p,
  input  logic                  sda_bit,
  input  logic [DATA_W-1:0]     rd_value,
  output logic                  sda_pull,
  output logic                  wr_pulse,
  output logic [DATA_W-1:0]     wr_value
);

  localparam int NBYTES = DATA_W / 8;
  localparam int BCW    = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam int HOLD_W = DATA_W - 8;

  node_st_e          st;
  logic [3:0]        bitcnt;
  logic [7:0]        sh;
  logic [DATA_W-1:0] tx;
  logic [HOLD_W-1:0] hold;
  logic [BCW-1:0]    bcnt;
  logic              rw, seen, mack;

  always_ff @(posedge clk) begin
    wr_pulse <= 1'b0;
    if (rst) begin
      st       <= ST_IDLE;
      bitcnt   <= '0;
      sh       <= '0;
      tx       <= '0;
      hold     <= '0;
      bcnt     <= '0;
      rw       <= 1'b0;
      seen     <= 1'b0;
      mack     <= 1'b0;
      sda_pull <= 1'b0;
      wr_value <= '0;
    end else if (start_p) begin
      st       <= ST_ADDR;
      bitcnt   <= '0;
      bcnt     <= '0;
      seen     <= 1'b0;
      sda_pull <= 1'b0;
    end else if (stop_p) begin
      st       <= ST_IDLE;
      seen     <= 1'b0;
      sda_pull <= 1'b0;
    end else begin
      unique case (st)
        ST_ADDR: begin
          if (scl_rise) begin
            sh     <= {sh[6:0], sda_bit};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            if (sh[7:1] == my_addr) begin
              st       <= ST_AACK;
              rw       <= sh[0];
              sda_pull <= 1'b1;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        ST_AACK: begin
          if (scl_rise) begin
            seen <= 1'b1;
          end else if (scl_fall && seen) begin
            seen   <= 1'b0;
            bitcnt <= '0;
            if (rw) begin
              st       <= ST_RDATA;
              tx       <= rd_value;
              sda_pull <= ~rd_value[DATA_W-1];
            end else begin
              st       <= ST_WDATA;
              sda_pull <= 1'b0;
            end
          end
        end
        ST_WDATA: begin
          if (scl_rise) begin
            sh     <= {sh[6:0], sda_bit};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            st       <= ST_WACK;
            sda_pull <= 1'b1;
            bitcnt   <= '0;
            if (bcnt == BCW'(NBYTES - 1)) begin
              bcnt     <= '0;
              wr_pulse <= WRITABLE;
              wr_value <= {hold, sh};
            end else begin
              bcnt <= bcnt + BCW'(1);
              hold <= HOLD_W'({hold, sh});
            end
          end
        end
        ST_WACK: begin
          if (scl_rise) begin
            seen <= 1'b1;
          end else if (scl_fall && seen) begin
            seen     <= 1'b0;
            st       <= ST_WDATA;
            sda_pull <= 1'b0;
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall) begin
            tx <= {tx[DATA_W-2:0], tx[DATA_W-1]};
            if (bitcnt == 4'd8) begin
              st       <= ST_RACK;
              bitcnt   <= '0;
              sda_pull <= 1'b0;
            end else begin
              sda_pull <= ~tx[DATA_W-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            seen <= 1'b1;
            mack <= ~sda_bit;
          end else if (scl_fall && seen) begin
            seen <= 1'b0;
            if (mack) begin
              st       <= ST_RDATA;
              sda_pull <= ~tx[DATA_W-1];
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2c_alu_regs.sv
module i2c_alu_regs
  import i2c_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic [BUS_ADDR_W-1:0] addr_opa,
  input  logic [BUS_ADDR_W-1:0] addr_opb,
  input  logic [BUS_ADDR_W-1:0] addr_ctl,
  input  logic [BUS_ADDR_W-1:0] addr_res,
  output logic                  scl_oe,
  output logic                  sda_oe
);

  localparam int NODES   = 4;
  localparam int RES_IDX = NODES - 1;

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_p, stop_p;

  logic [BUS_ADDR_W-1:0] node_addr [NODES];
  logic [DATA_W-1:0]     node_rd   [NODES];
  logic [DATA_W-1:0]     node_wval [NODES];
  logic [NODES-1:0]      wr_vec;
  logic [NODES-1:0]      pull_vec;

  logic [DATA_W-1:0] op_a, op_b, ctl_r, res_r, alu_y;
  logic              upd_q;

  i2c_bus_sense u_sense (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_p  (start_p),
    .stop_p   (stop_p)
  );

  assign node_addr[0] = addr_opa;
  assign node_addr[1] = addr_opb;
  assign node_addr[2] = addr_ctl;
  assign node_addr[3] = addr_res;

  assign node_rd[0] = op_a;
  assign node_rd[1] = op_b;
  assign node_rd[2] = ctl_r;
  assign node_rd[3] = res_r;

  for (genvar gi = 0; gi < NODES; gi++) begin : g_node
    i2c_reg_node #(
      .DATA_W   (DATA_W),
      .WRITABLE (gi != RES_IDX)
    ) u_node (
      .clk      (clk),
      .rst      (rst),
      .my_addr  (node_addr[gi]),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_p  (start_p),
      .stop_p   (stop_p),
      .sda_bit  (sda_lvl),
      .rd_value (node_rd[gi]),
      .sda_pull (pull_vec[gi]),
      .wr_pulse (wr_vec[gi]),
      .wr_value (node_wval[gi])
    );
  end

  i2c_alu_core #(.DATA_W(DATA_W)) u_alu (
    .a  (op_a),
    .b  (op_b),
    .op (alu_op_e'(ctl_r[OP_SEL_W-1:0])),
    .y  (alu_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_a  <= '0;
      op_b  <= '0;
      ctl_r <= '0;
      res_r <= '0;
      upd_q <= 1'b0;
    end else begin
      if (wr_vec[0]) op_a  <= node_wval[0];
      if (wr_vec[1]) op_b  <= node_wval[1];
      if (wr_vec[2]) ctl_r <= node_wval[2];
      upd_q <= |wr_vec;
      if (upd_q) res_r <= alu_y;
    end
  end

  assign sda_oe = |pull_vec;
  assign scl_oe = 1'b0;

endmodule

// File: rtl/i2c_alu_regs_chk.sv
module i2c_alu_regs_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_lvl,
  input logic              start_p,
  input logic              stop_p,
  input logic              sda_oe,
  input logic [3:0]        wr_vec,
  input logic [DATA_W-1:0] res
);

  p_release_on_stop_r10: assert property (@(posedge clk) disable iff (rst)
    stop_p |=> !sda_oe);

  p_drive_moves_scl_low_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> (!$past(scl_lvl) || $past(start_p) || $past(stop_p)));

  p_single_writer_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_vec));

  p_result_node_readonly_r8: assert property (@(posedge clk) disable iff (rst)
    !wr_vec[3]);

  p_res_after_write_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(res) |-> $past(|wr_vec, 2));

endmodule

bind i2c_alu_regs i2c_alu_regs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .scl_lvl (scl_lvl),
  .start_p (start_p),
  .stop_p  (stop_p),
  .sda_oe  (sda_oe),
  .wr_vec  (wr_vec),
  .res     (res_r)
);

// File: tb/i2c_alu_regs_tb.sv
module i2c_alu_regs_tb;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam int NVEC       = 12;

  // {op[2:0], a[15:0], b[15:0], expected[15:0]}
  localparam logic [50:0] VEC [NVEC] = '{
    {3'd0, 16'h1234, 16'h0F0F, 16'h2143},
    {3'd1, 16'h1234, 16'h0F0F, 16'h0325},
    {3'd2, 16'h1234, 16'h0F0F, 16'h0204},
    {3'd3, 16'h1234, 16'h0F0F, 16'h1F3F},
    {3'd4, 16'h1234, 16'h0F0F, 16'h1D3B},
    {3'd5, 16'h1234, 16'h0F0F, 16'h2468},
    {3'd6, 16'h1234, 16'h0F0F, 16'h091A},
    {3'd7, 16'h1234, 16'h0F0F, 16'h1234},
    {3'd0, 16'hFFFF, 16'h0001, 16'h0000},
    {3'd1, 16'h0000, 16'h0001, 16'hFFFF},
    {3'd5, 16'h8001, 16'h0000, 16'h0002},
    {3'd6, 16'h8001, 16'h0000, 16'h4000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic [6:0] a_opa = 7'h10, a_opb = 7'h11, a_ctl = 7'h12, a_res = 7'h13;
  logic scl_oe, sda_oe, scl_line, sda_line;

  int n_chk = 0;
  int n_bad = 0;

  assign scl_line = m_scl & ~scl_oe;
  assign sda_line = m_sda & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_alu_regs u_dut (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_line),
    .sda_i    (sda_line),
    .addr_opa (a_opa),
    .addr_opb (a_opb),
    .addr_ctl (a_ctl),
    .addr_res (a_res),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe)
  );

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq();
    m_scl = 1'b1; wq();
    m_sda = 1'b0; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq();
    m_scl = 1'b1; wq();
    m_sda = 1'b1; wq();
  endtask

  task automatic put_bit(input logic b);
    m_sda = b;    wq();
    m_scl = 1'b1; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; wq();
    m_scl = 1'b1; wq();
    b = sda_line;
    m_scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = !b;
  endtask

  task automatic recv_byte(input logic last, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(last);
  endtask

  task automatic wr16(input logic [6:0] ad, input logic [15:0] v, output logic [2:0] acks);
    logic k;
    bus_start();
    send_byte({ad, 1'b0}, k); acks[2] = k;
    send_byte(v[15:8], k);    acks[1] = k;
    send_byte(v[7:0], k);     acks[0] = k;
    bus_stop();
  endtask

  task automatic rd16(input logic [6:0] ad, output logic [15:0] v, output logic ack);
    logic [7:0] hi, lo;
    bus_start();
    send_byte({ad, 1'b1}, ack);
    recv_byte(1'b0, hi);
    recv_byte(1'b1, lo);
    bus_stop();
    v = {hi, lo};
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [2:0]  acks;
    logic [15:0] v;
    logic        k;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    // R1 / R10: idle drives after reset
    chk(sda_oe == 1'b0 && scl_oe == 1'b0, "R1 drives released after reset", {sda_oe, scl_oe}, 0);
    rd16(a_res, v, k);
    chk(k && v == 16'h0000, "R1 result reads zero after reset", v, 0);
    rd16(a_opa, v, k);
    chk(k && v == 16'h0000, "R1 operand A reads zero after reset", v, 0);

    // R6 / R7 / R2 / R4: vector table
    for (int i = 0; i < NVEC; i++) begin
      wr16(a_opa, VEC[i][47:32], acks);
      chk(acks == 3'b111, "R2 R4 operand A acks", acks, 3'b111);
      wr16(a_opb, VEC[i][31:16], acks);
      chk(acks == 3'b111, "R4 operand B acks", acks, 3'b111);
      wr16(a_ctl, {13'd0, VEC[i][50:48]}, acks);
      chk(acks == 3'b111, "R4 selector acks", acks, 3'b111);
      rd16(a_res, v, k);
      chk(k && v == VEC[i][15:0], "R6 R7 result of vector", v, VEC[i][15:0]);
      chk(sda_oe == 1'b0 && scl_oe == 1'b0, "R5 R10 released after read", {sda_oe, scl_oe}, 0);
    end

    // R5: read back operands
    rd16(a_opa, v, k);
    chk(k && v == 16'h8001, "R5 read operand A", v, 16'h8001);
    rd16(a_ctl, v, k);
    chk(k && v == 16'h0006, "R5 read selector", v, 16'h0006);

    // R7: selector-only write recomputes (A=0x8001, B=0)
    wr16(a_ctl, 16'h0007, acks);
    rd16(a_res, v, k);
    chk(v == 16'h8001, "R7 selector write recomputes result", v, 16'h8001);
    wr16(a_opb, 16'h0002, acks);
    wr16(a_ctl, 16'h0001, acks);
    rd16(a_res, v, k);
    chk(v == 16'h7FFF, "R7 R6 sub after operand write", v, 16'h7FFF);

    // R3: unmatched address
    wr16(7'h55, 16'hBEEF, acks);
    chk(acks == 3'b000, "R3 no ack on unmatched address", acks, 0);
    rd16(a_opa, v, k);
    chk(v == 16'h8001, "R3 operand A unchanged", v, 16'h8001);

    // R8: write to result node
    wr16(a_res, 16'hDEAD, acks);
    chk(acks == 3'b111, "R8 result node acks write", acks, 3'b111);
    rd16(a_res, v, k);
    chk(v == 16'h7FFF, "R8 result unchanged", v, 16'h7FFF);

    // R9: only one data byte then STOP
    bus_start();
    send_byte({a_opa, 1'b0}, k);
    send_byte(8'hAB, k);
    bus_stop();
    rd16(a_opa, v, k);
    chk(v == 16'h8001, "R9 single byte discarded", v, 16'h8001);

    // R9: STOP in mid-byte
    bus_start();
    send_byte({a_opa, 1'b0}, k);
    send_byte(8'hAB, k);
    for (int i = 0; i < 3; i++) put_bit(1'b0);
    bus_stop();
    rd16(a_opa, v, k);
    chk(v == 16'h8001, "R9 stop mid-byte discarded", v, 16'h8001);

    // R9: repeated START mid-byte, then a full write to B
    bus_start();
    send_byte({a_opa, 1'b0}, k);
    send_byte(8'h12, k);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_start();
    send_byte({a_opb, 1'b0}, acks[2]);
    send_byte(8'h43, acks[1]);
    send_byte(8'h21, acks[0]);
    bus_stop();
    chk(acks == 3'b111, "R9 write after repeated start acked", acks, 3'b111);
    rd16(a_opa, v, k);
    chk(v == 16'h8001, "R9 repeated start discarded A", v, 16'h8001);
    rd16(a_opb, v, k);
    chk(v == 16'h4321, "R9 B written after repeated start", v, 16'h4321);

    // R11: relocate operand A
    a_opa = 7'h33;
    repeat (4) @(negedge clk);
    wr16(7'h10, 16'h0F0F, acks);
    chk(acks == 3'b000, "R11 old address ignored", acks, 0);
    wr16(7'h33, 16'h5A5A, acks);
    chk(acks == 3'b111, "R11 new address acked", acks, 3'b111);
    rd16(7'h33, v, k);
    chk(k && v == 16'h5A5A, "R11 read at new address", v, 16'h5A5A);
    chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R10 lines released at end", {sda_oe, scl_oe}, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule